// File: doc/BRIEF.md
# Four-Channel Interrupt and Reset Controller

This block gathers completion and fault events from four accelerator channels into a 64-bit status register. The register is read as a high word and a low word. Each status bit stays set until software writes a one to the matching bit of a clear word. A 64-bit mask, also split into two words, selects which status bits reach the single interrupt output. One of two register layouts is chosen at elaboration. The layouts differ in where the channel bits sit, in the polarity of the mask, and in where the reset controls are. Only the newer layout can restart a faulted channel without resetting it.

The block also sequences resets. A global software reset bit starts a fixed sequence that resets every channel. A per-channel reset bit does the same for one channel. Both bits read back as one while their sequence runs and then clear themselves. In the newer layout a per-channel continue bit gives the channel a one-cycle restart strobe. Register access is a plain 32-bit word bus. A write is taken on the clock edge when the write enable is high. Read data follows the address combinationally.

Top module: `chan_irq_ctrl`

## Requirements
- R1: After reset all status bits read 0, and no reset pulse, continue strobe or interrupt is active. Both mask words read 0x0000_0000 in the newer layout and 0xFFFF_FFFF in the legacy layout, so every source starts disabled.
- R2: Newer layout: an event on channel n sets high-status bit 2n (done) or 2n+1 (error) on the next clock edge. The random-number-unit error input sets low-status bit 17. The bus transfer error input has no effect. The status words are at 0x1010 (high) and 0x1014 (low).
- R3: Legacy layout: done events of channels 0, 1, 2 and 3 set high-status bits 28, 30, 16 and 18. Error events set bits 29, 31, 17 and 19. The random-number-unit error input sets low bit 25, and the bus transfer error input sets low bit 6.
- R4: A write to 0x1018 (high) or 0x101C (low) clears each status bit whose write-data bit is 1 and leaves the others alone. Both clear words read 0.
- R5: Status bits are sticky. When an event and a clear of the same bit fall on the same edge, the bit ends up set.
- R6: The mask words are read/write at 0x1008 (high) and 0x100C (low). In the newer layout a mask bit of 1 enables its status bit, and in the legacy layout a mask bit of 0 enables it. irqOut is high exactly when at least one set status bit is enabled.
- R7: Writing a 1 to bit 0 (newer) or bit 24 (legacy) of the word at 0x1030 starts an 8-cycle global reset that begins on the next cycle. For those 8 cycles the bit reads 1 and all chanRstPulse bits are high. At each edge of the sequence the whole status is cleared, events are dropped, the masks return to their reset value, and channel-word writes are ignored.
- R8: The word of channel n is at 0x1100 + 0x100·n. Writing 1 to bit 0 of offset 0x8 (newer) or offset 0xC (legacy) starts an 8-cycle reset of that channel on the next cycle. For those 8 cycles the bit reads 1 and chanRstPulse[n] is high. At each of those edges the done and error bits of channel n are cleared and its events are dropped.
- R9: Newer layout only: writing offset 0x8 of channel n with bit 1 set and bit 0 clear raises chanCont[n] for the following cycle, and bit 1 reads 1 in that cycle. The write is ignored while the channel is in reset. In the legacy layout chanCont stays 0 and that word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Word write strobe |
| busAddr | input | 16 | Word byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| doneEvt | input | 4 | Per-channel completion event |
| errEvt | input | 4 | Per-channel fault event |
| rngErrEvt | input | 1 | Random-number-unit fault event |
| xferErrEvt | input | 1 | Bus transfer fault event (legacy layout only) |
| irqOut | output | 1 | Combined interrupt |
| chanRstPulse | output | 4 | Per-channel reset, high during a reset sequence |
| chanCont | output | 4 | Per-channel one-cycle continue strobe |

## Verification
Several functions can land on the same clock edge: an event and a clear write of its status bit, an event and an active reset sequence of its channel, and a continue write and that channel's reset. The bench provokes each pairing with directed writes timed to the same cycle as the events. It then runs a long random mix of writes and events on both layouts at once. A behavioural model applies the priority rules (event over clear, reset over event and continue) and is compared on every clock with the interrupt, the reset pulses, the continue strobes and the read data.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;

  localparam int CH_COUNT = 4;
  localparam int WORD_W   = 32;

  localparam logic [15:0] OFS_MASK_HI = 16'h1008;
  localparam logic [15:0] OFS_MASK_LO = 16'h100C;
  localparam logic [15:0] OFS_STAT_HI = 16'h1010;
  localparam logic [15:0] OFS_STAT_LO = 16'h1014;
  localparam logic [15:0] OFS_CLR_HI  = 16'h1018;
  localparam logic [15:0] OFS_CLR_LO  = 16'h101C;
  localparam logic [15:0] OFS_MASTER  = 16'h1030;

  localparam int XFER_ERR_POS = 6;

  // strobes from the control unit to the status datapath
  typedef struct packed {
    logic                maskHiWr;
    logic                maskLoWr;
    logic                clrHiWr;
    logic                clrLoWr;
    logic                globHold;
    logic [CH_COUNT-1:0] chanHold;
  } ctlStrobe_t;

  function automatic int doneBitPos(bit legacy, int ch);
    if (legacy) return ((ch >= 2) ? 16 : 28) + 2 * (ch % 2);
    return 2 * ch;
  endfunction

  function automatic int rngBitPos(bit legacy);
    return legacy ? 25 : 17;
  endfunction

  function automatic int globRstPos(bit legacy);
    return legacy ? 24 : 0;
  endfunction

endpackage

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
  import chan_irq_pkg::*;
#(
  parameter bit LEGACY     = 1'b0,
  parameter int ADDR_W     = 16,
  parameter int RST_CYCLES = 8,
  parameter int CH_BASE    = 'h1100,
  parameter int CH_STRIDE  = 'h0100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [WORD_W-1:0]   busWdata,
  output ctlStrobe_t          strobe,
  output logic [CH_COUNT-1:0] chanRstPulse,
  output logic [CH_COUNT-1:0] chanCont,
  output logic [WORD_W-1:0]   ctlRdata
);

  localparam int CNT_W   = $clog2(RST_CYCLES + 1);
  localparam int RST_OFF = LEGACY ? 'hC : 'h8;
  localparam int CNT_OFF = 'h8;
  localparam int GPOS    = globRstPos(LEGACY);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0]    globCnt;
  logic                globBusy;
  logic [CH_COUNT-1:0] chanBusy;
  logic [CH_COUNT-1:0] chanHold;

  assign globBusy = (globCnt != '0);
  assign chanHold = chanBusy | {CH_COUNT{globBusy}};

  always_ff @(posedge clk) begin
    if (!rstN)          globCnt <= '0;
    else if (globBusy)  globCnt <= globCnt - 1'b1;
    else if (busWrEn && busAddr == ADDR_W'(OFS_MASTER) && busWdata[GPOS])
      globCnt <= CNT_LOAD;
  end

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    localparam logic [ADDR_W-1:0] RST_ADDR = ADDR_W'(CH_BASE + ch * CH_STRIDE + RST_OFF);
    localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(CH_BASE + ch * CH_STRIDE + CNT_OFF);
    logic [CNT_W-1:0] rstCnt;

    always_ff @(posedge clk) begin
      if (!rstN)               rstCnt <= '0;
      else if (rstCnt != '0)   rstCnt <= rstCnt - 1'b1;
      else if (!globBusy && busWrEn && busAddr == RST_ADDR && busWdata[0])
        rstCnt <= CNT_LOAD;
    end
    assign chanBusy[ch] = (rstCnt != '0);

    if (LEGACY) begin : g_nocont
      assign chanCont[ch] = 1'b0;
    end else begin : g_cont
      logic contQ;
      always_ff @(posedge clk) begin
        if (!rstN) contQ <= 1'b0;
        else       contQ <= busWrEn && busAddr == CNT_ADDR && busWdata[1]
                            && !busWdata[0] && !chanHold[ch];
      end
      assign chanCont[ch] = contQ;
    end
  end

  always_comb begin
    strobe.maskHiWr = busWrEn && busAddr == ADDR_W'(OFS_MASK_HI);
    strobe.maskLoWr = busWrEn && busAddr == ADDR_W'(OFS_MASK_LO);
    strobe.clrHiWr  = busWrEn && busAddr == ADDR_W'(OFS_CLR_HI);
    strobe.clrLoWr  = busWrEn && busAddr == ADDR_W'(OFS_CLR_LO);
    strobe.globHold = globBusy;
    strobe.chanHold = chanHold;
  end

  assign chanRstPulse = chanHold;

  always_comb begin
    ctlRdata = '0;
    if (busAddr == ADDR_W'(OFS_MASTER)) ctlRdata[GPOS] = globBusy;
    for (int ch = 0; ch < CH_COUNT; ch++) begin
      if (busAddr == ADDR_W'(CH_BASE + ch * CH_STRIDE + RST_OFF))
        ctlRdata[0] = chanBusy[ch];
      if (!LEGACY && busAddr == ADDR_W'(CH_BASE + ch * CH_STRIDE + CNT_OFF))
        ctlRdata[1] = chanCont[ch];
    end
  end

endmodule

// File: rtl/irq_status_path.sv
module irq_status_path
  import chan_irq_pkg::*;
#(
  parameter bit LEGACY = 1'b0,
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [WORD_W-1:0]   busWdata,
  input  logic [CH_COUNT-1:0] doneEvt,
  input  logic [CH_COUNT-1:0] errEvt,
  input  logic                rngErrEvt,
  input  logic                xferErrEvt,
  output logic [WORD_W-1:0]   statHi,
  output logic [WORD_W-1:0]   statLo,
  output logic                irqOut,
  output logic [WORD_W-1:0]   dpRdata
);

  localparam logic [WORD_W-1:0] MASK_RST = LEGACY ? '1 : '0;
  localparam int RNG_POS = rngBitPos(LEGACY);

  logic [WORD_W-1:0] maskHi, maskLo;
  logic [WORD_W-1:0] setHi, setLo, holdHi, clrHi, clrLo;
  logic [WORD_W-1:0] enHi, enLo;
  logic [WORD_W-1:0] chanSet  [CH_COUNT];
  logic [WORD_W-1:0] chanBits [CH_COUNT];

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_pos
    localparam int DP = doneBitPos(LEGACY, ch);
    localparam int EP = DP + 1;
    assign chanBits[ch] = (WORD_W'(1) << DP) | (WORD_W'(1) << EP);
    assign chanSet[ch]  = strobe.chanHold[ch] ? '0 :
                          ((WORD_W'(doneEvt[ch]) << DP) | (WORD_W'(errEvt[ch]) << EP));
  end

  always_comb begin
    setHi  = '0;
    holdHi = '0;
    for (int ch = 0; ch < CH_COUNT; ch++) begin
      setHi = setHi | chanSet[ch];
      if (strobe.chanHold[ch]) holdHi = holdHi | chanBits[ch];
    end
    setLo = '0;
    if (!strobe.globHold) begin
      setLo[RNG_POS] = rngErrEvt;
      if (LEGACY) setLo[XFER_ERR_POS] = xferErrEvt;
    end
  end

  assign clrHi = strobe.clrHiWr ? busWdata : '0;
  assign clrLo = strobe.clrLoWr ? busWdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.globHold) begin
      statHi <= '0;
      statLo <= '0;
      maskHi <= MASK_RST;
      maskLo <= MASK_RST;
    end else begin
      statHi <= ((statHi & ~clrHi) | setHi) & ~holdHi;
      statLo <= (statLo & ~clrLo) | setLo;
      if (strobe.maskHiWr) maskHi <= busWdata;
      if (strobe.maskLoWr) maskLo <= busWdata;
    end
  end

  assign enHi   = LEGACY ? ~maskHi : maskHi;
  assign enLo   = LEGACY ? ~maskLo : maskLo;
  assign irqOut = (|(statHi & enHi)) | (|(statLo & enLo));

  always_comb begin
    case (busAddr)
      ADDR_W'(OFS_MASK_HI): dpRdata = maskHi;
      ADDR_W'(OFS_MASK_LO): dpRdata = maskLo;
      ADDR_W'(OFS_STAT_HI): dpRdata = statHi;
      ADDR_W'(OFS_STAT_LO): dpRdata = statLo;
      default:              dpRdata = '0;
    endcase
  end

endmodule

// File: rtl/chan_irq_ctrl.sv
module chan_irq_ctrl
  import chan_irq_pkg::*;
#(
  parameter bit LEGACY     = 1'b0,
  parameter int ADDR_W     = 16,
  parameter int RST_CYCLES = 8,
  parameter int CH_BASE    = 'h1100,
  parameter int CH_STRIDE  = 'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [3:0]        doneEvt,
  input  logic [3:0]        errEvt,
  input  logic              rngErrEvt,
  input  logic              xferErrEvt,
  output logic              irqOut,
  output logic [3:0]        chanRstPulse,
  output logic [3:0]        chanCont
);

  ctlStrobe_t        strobe;
  logic [WORD_W-1:0] ctlRdata, dpRdata;
  logic [WORD_W-1:0] statHi, statLo;

  irq_ctrl_unit #(
    .LEGACY(LEGACY), .ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES),
    .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .strobe(strobe), .chanRstPulse(chanRstPulse),
    .chanCont(chanCont), .ctlRdata(ctlRdata)
  );

  irq_status_path #(.LEGACY(LEGACY), .ADDR_W(ADDR_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWdata(busWdata), .doneEvt(doneEvt), .errEvt(errEvt),
    .rngErrEvt(rngErrEvt), .xferErrEvt(xferErrEvt), .statHi(statHi),
    .statLo(statLo), .irqOut(irqOut), .dpRdata(dpRdata)
  );

  assign busRdata = ctlRdata | dpRdata;

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import chan_irq_pkg::*;
#(
  parameter bit LEGACY     = 1'b0,
  parameter int ADDR_W     = 16,
  parameter int RST_CYCLES = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [3:0]        doneEvt,
  input logic [3:0]        errEvt,
  input logic              irqOut,
  input logic [3:0]        chanRstPulse,
  input logic [3:0]        chanCont,
  input logic [31:0]       statHi,
  input logic [31:0]       statLo
);

  localparam int D0 = doneBitPos(LEGACY, 0);
  localparam int E0 = D0 + 1;

  int runLen;
  always_ff @(posedge clk) begin
    if (!rstN)                runLen <= 0;
    else if (chanRstPulse[0]) runLen <= runLen + 1;
    else                      runLen <= 0;
  end

  assert_quiet_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statHi == '0 && statLo == '0) |-> !irqOut);

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (doneEvt[0] && !chanRstPulse[0]) |=> statHi[D0]);

  assert_clear_hi_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_CLR_HI) && doneEvt == '0 && errEvt == '0)
    |=> ((statHi & $past(busWdata)) == '0));

  assert_hold_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    chanRstPulse[0] |=> (!statHi[D0] && !statHi[E0]));

  // a contiguous run of chanRstPulse[0] may chain two sequences at most
  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    runLen <= 2 * RST_CYCLES);

  if (LEGACY) begin : g_leg
    assert_no_cont_R9: assert property (@(posedge clk) disable iff (!rstN)
      chanCont == '0);
  end else begin : g_new
    assert_cont_after_write_R9: assert property (@(posedge clk) disable iff (!rstN)
      chanCont[0] |-> $past(busWrEn));
  end

endmodule

bind chan_irq_ctrl irq_ctrl_chk #(
  .LEGACY(LEGACY), .ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWdata(busWdata), .doneEvt(doneEvt), .errEvt(errEvt), .irqOut(irqOut),
  .chanRstPulse(chanRstPulse), .chanCont(chanCont), .statHi(statHi),
  .statLo(statLo)
);

// File: tb/test_chan_irq_ctrl.sv
module test_chan_irq_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0]  doneEvt = '0, errEvt = '0;
  logic        rngErrEvt = 1'b0, xferErrEvt = 1'b0;

  logic [31:0] rdata [2];
  logic        irq   [2];
  logic [3:0]  pulse [2];
  logic [3:0]  cont  [2];

  always #2.5 clk = ~clk;

  chan_irq_ctrl #(.LEGACY(1'b0)) i_chan_irq_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rdata[0]), .doneEvt(doneEvt), .errEvt(errEvt),
    .rngErrEvt(rngErrEvt), .xferErrEvt(xferErrEvt), .irqOut(irq[0]),
    .chanRstPulse(pulse[0]), .chanCont(cont[0]));

  chan_irq_ctrl #(.LEGACY(1'b1)) i_chan_irq_ctrl_legacy (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rdata[1]), .doneEvt(doneEvt), .errEvt(errEvt),
    .rngErrEvt(rngErrEvt), .xferErrEvt(xferErrEvt), .irqOut(irq[1]),
    .chanRstPulse(pulse[1]), .chanCont(cont[1]));

  int    nCmp = 0, nBad = 0;
  bit    finished = 1'b0;
  string phaseTag = "R1";

  // behavioural model, index 0 = newer layout, 1 = legacy layout
  logic [31:0] mStHi [2], mStLo [2], mMkHi [2], mMkLo [2];
  int          mGCnt [2];
  int          mChCnt [2][4];
  bit          mCont [2][4];

  function automatic int dpos(int L, int ch);
    return L ? (((ch >= 2) ? 16 : 28) + 2 * (ch % 2)) : 2 * ch;
  endfunction

  function automatic logic [31:0] mRead(int L, logic [15:0] a);
    logic [31:0] r = '0;
    case (a)
      16'h1008: r = mMkHi[L];
      16'h100C: r = mMkLo[L];
      16'h1010: r = mStHi[L];
      16'h1014: r = mStLo[L];
      16'h1030: r[L ? 24 : 0] = (mGCnt[L] > 0);
      default: ;
    endcase
    for (int ch = 0; ch < 4; ch++) begin
      if (a == 16'(32'h1108 + ch * 256) && L == 0) r = {30'd0, mCont[L][ch], mChCnt[L][ch] > 0};
      if (a == 16'(32'h110C + ch * 256) && L == 1) r = {31'd0, mChCnt[L][ch] > 0};
    end
    return r;
  endfunction

  task automatic modelReset();
    for (int L = 0; L < 2; L++) begin
      mStHi[L] = '0; mStLo[L] = '0;
      mMkHi[L] = L ? '1 : '0; mMkLo[L] = L ? '1 : '0;
      mGCnt[L] = 0;
      for (int ch = 0; ch < 4; ch++) begin mChCnt[L][ch] = 0; mCont[L][ch] = 0; end
    end
  endtask

  task automatic modelStep();
    for (int L = 0; L < 2; L++) begin
      bit gB = (mGCnt[L] > 0);
      logic [31:0] nHi = mStHi[L], nLo = mStLo[L];
      bit hold [4];
      if (busWrEn && busAddr == 16'h1018) nHi &= ~busWdata;
      if (busWrEn && busAddr == 16'h101C) nLo &= ~busWdata;
      for (int ch = 0; ch < 4; ch++) begin
        hold[ch] = gB || (mChCnt[L][ch] > 0);
        if (hold[ch]) begin
          nHi[dpos(L, ch)] = 1'b0; nHi[dpos(L, ch) + 1] = 1'b0;
        end else begin
          if (doneEvt[ch]) nHi[dpos(L, ch)] = 1'b1;
          if (errEvt[ch])  nHi[dpos(L, ch) + 1] = 1'b1;
        end
      end
      if (!gB) begin
        if (rngErrEvt) nLo[L ? 25 : 17] = 1'b1;
        if (L == 1 && xferErrEvt) nLo[6] = 1'b1;
      end
      if (gB) begin
        nHi = '0; nLo = '0;
        mMkHi[L] = L ? '1 : '0; mMkLo[L] = L ? '1 : '0;
      end else begin
        if (busWrEn && busAddr == 16'h1008) mMkHi[L] = busWdata;
        if (busWrEn && busAddr == 16'h100C) mMkLo[L] = busWdata;
      end
      mStHi[L] = nHi; mStLo[L] = nLo;
      for (int ch = 0; ch < 4; ch++) begin
        logic [15:0] base = 16'(32'h1100 + ch * 256);
        mCont[L][ch] = (L == 0) && busWrEn && busAddr == base + 16'h8 &&
                       busWdata[1] && !busWdata[0] && !hold[ch];
        if (mChCnt[L][ch] > 0) mChCnt[L][ch]--;
        else if (!gB && busWrEn && busAddr == base + (L ? 16'hC : 16'h8) && busWdata[0])
          mChCnt[L][ch] = 8;
      end
      if (gB) mGCnt[L]--;
      else if (busWrEn && busAddr == 16'h1030 && busWdata[L ? 24 : 0]) mGCnt[L] = 8;
    end
  endtask

  task automatic chk(string what, int L, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s layout%0d: actual %h expected %h", phaseTag, what, L, act, exp);
    end
  endtask

  task automatic compareAll();
    for (int L = 0; L < 2; L++) begin
      logic [31:0] eIrq = '0;
      logic [3:0]  ePul, eCon;
      logic [31:0] enH = L ? ~mMkHi[L] : mMkHi[L];
      logic [31:0] enL = L ? ~mMkLo[L] : mMkLo[L];
      eIrq[0] = (|(mStHi[L] & enH)) | (|(mStLo[L] & enL));
      for (int ch = 0; ch < 4; ch++) begin
        ePul[ch] = (mGCnt[L] > 0) || (mChCnt[L][ch] > 0);
        eCon[ch] = mCont[L][ch];
      end
      chk("irqOut", L, {31'd0, irq[L]}, eIrq);
      chk("chanRstPulse", L, {28'd0, pulse[L]}, {28'd0, ePul});
      chk("chanCont", L, {28'd0, cont[L]}, {28'd0, eCon});
      chk("busRdata", L, rdata[L], mRead(L, busAddr));
    end
  endtask

  // one clock: compare now, advance model, move to next falling edge
  task automatic tick();
    #1;
    compareAll();
    modelStep();
    @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [15:0] a);
    busAddr = a;
    tick();
  endtask

  task automatic evts(logic [3:0] d, logic [3:0] e, logic r, logic x);
    doneEvt = d; errEvt = e; rngErrEvt = r; xferErrEvt = x;
  endtask

  localparam logic [15:0] ADDRS [12] = '{16'h1008, 16'h100C, 16'h1010, 16'h1014,
    16'h1018, 16'h101C, 16'h1030, 16'h1108, 16'h110C, 16'h1208, 16'h130C, 16'h1000};

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values
    phaseTag = "R1";
    rd(16'h1008); rd(16'h100C); rd(16'h1010); rd(16'h1014); rd(16'h1030);

    // R2 / R3: bit positions of each channel and the low-word sources
    phaseTag = "R2_R3";
    evts(4'b0101, 4'b1010, 1'b1, 1'b1); rd(16'h1010);
    evts(4'b1010, 4'b0101, 1'b0, 1'b0); rd(16'h1010);
    evts('0, '0, 1'b0, 1'b0); rd(16'h1010); rd(16'h1014);

    // R4: write-one-to-clear, zeros leave bits alone, clear words read 0
    phaseTag = "R4";
    wr(16'h1018, 32'h0000_00F0); rd(16'h1010);
    wr(16'h1018, 32'h0000_0000); rd(16'h1010);
    wr(16'h1018, 32'hF00F_000F); rd(16'h1010);
    wr(16'h101C, 32'h0200_0040); rd(16'h1014); rd(16'h1018);

    // R5: event on the same edge as its clear
    phaseTag = "R5";
    evts(4'b0001, '0, 1'b1, 1'b0);
    wr(16'h1018, 32'hFFFF_FFFF);
    wr(16'h101C, 32'hFFFF_FFFF);
    evts('0, '0, 1'b0, 1'b0); rd(16'h1010); rd(16'h1014);

    // R6: mask polarity per layout
    phaseTag = "R6";
    wr(16'h1008, 32'h0000_0001); rd(16'h1008);
    wr(16'h1008, 32'hFFFF_FFFE); rd(16'h1008);
    wr(16'h100C, 32'h0000_0000); rd(16'h1014);
    wr(16'h101C, 32'hFFFF_FFFF); rd(16'h1014);

    // R7: global reset with events arriving during it
    phaseTag = "R7";
    evts(4'b1111, 4'b1111, 1'b1, 1'b1); rd(16'h1010);
    wr(16'h1030, 32'h0100_0001);
    wr(16'h1208, 32'h1);
    for (int i = 0; i < 8; i++) rd(16'h1030);
    evts('0, '0, 1'b0, 1'b0); rd(16'h1008); rd(16'h1010);

    // R8: per-channel reset in both layouts, events held off
    phaseTag = "R8";
    evts(4'b0100, 4'b0100, 1'b0, 1'b0); rd(16'h1010);
    wr(16'h1308, 32'h1);
    wr(16'h130C, 32'h1);
    for (int i = 0; i < 9; i++) rd(i % 2 ? 16'h1308 : 16'h130C);
    evts('0, '0, 1'b0, 1'b0); rd(16'h1010); rd(16'h1010);

    // R9: continue strobe, also against a channel in reset
    phaseTag = "R9";
    wr(16'h1108, 32'h2); rd(16'h1108);
    wr(16'h1108, 32'h3); rd(16'h1108);
    wr(16'h1208, 32'h1);
    wr(16'h1208, 32'h2); rd(16'h1208);
    repeat (10) rd(16'h1208);
    wr(16'h1208, 32'h2); rd(16'h110C);

    // mixed random traffic on both layouts
    phaseTag = "R5_random";
    for (int i = 0; i < 4000; i++) begin
      evts(4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)),
           4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)),
           1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 7) == 0));
      busAddr  = ADDRS[$urandom_range(0, 11)];
      busWdata = $urandom();
      busWrEn  = ($urandom_range(0, 3) == 0) && !(busAddr == 16'h1030 && $urandom_range(0, 3) != 0);
      tick();
    end
    busWrEn = 1'b0;
    evts('0, '0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule